// File: doc/BRIEF.md
# Two-Tier Maskable Interrupt Controller

This block gathers single-cycle event pulses from several circuit groups and holds each one in a sticky secondary status bit. Each secondary bit has its own mask. The unmasked secondary bits of a group are ORed into one primary summary bit for that group. The primary bits have masks of their own. The OR of the unmasked primary bits drives a registered, active-low interrupt request to the host.

The host works through a simple parallel register port. Reads are combinational and have no side effects. A write of ones to a secondary status word clears the selected bits. Mask words are plain read/write registers. The number of groups and the number of events per group are parameters, and the register map scales with them.

Top module: `irq_two_tier_ctrl`

## Requirements
- R1: Reset clears every secondary status bit. It sets every secondary mask bit and every primary mask bit to 1, meaning masked. The interrupt output `irq_n_o` is high after reset.
- R2: An event pulse on `evt_i[g*GRP_W+b]` sets secondary bit b of group g at the next clock edge. The bit stays at 1 after the pulse has ended.
- R3: Writing to a secondary status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: Reading any register leaves every status bit unchanged, so a second read returns the same value.
- R5: Primary bit g reads as 1 exactly when group g has at least one secondary bit that is set and whose mask bit is 0.
- R6: A masked secondary bit still latches and reads back as set. It does not contribute to its primary bit.
- R7: `irq_n_o` is low exactly when some primary bit is 1 and its primary mask bit is 0. It follows that condition one clock edge later.
- R8: If an event pulse and a write-one-to-clear hit the same secondary bit in the same cycle, the bit ends up set. Other bits named by that write are still cleared.
- R9: Register map with the defaults NUM_GRP=4 and GRP_W=8. Addresses 0..3 hold the secondary status of groups 0..3, and bit b of each word is event b of that group. Addresses 4..7 hold the secondary masks of groups 0..3. Address 8 holds the primary status, with bit g for group g; it is read-only. Address 9 holds the primary mask, with bit g for group g. Unmapped addresses read 0 and ignore writes.
- R10: A primary mask bit set to 1 keeps a pending primary bit from driving `irq_n_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_GRP*GRP_W | Single-cycle event pulses, group-major order |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | GRP_W | Register write data |
| rdata_o | output | GRP_W | Combinational read data for `addr_i` |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a clear of the same bit. The bench reaches it by driving both in a single cycle, first with a clear of only the colliding bit and then with a clear of the whole word while a neighbouring bit is pulsed. The masking paths are also hard to observe, because a latched bit can be hidden at two levels. The stimulus holds a set bit behind each mask in turn. At each step it checks the primary word and `irq_n_o`.

// File: rtl/irq_tt_pkg.sv
package irq_tt_pkg;

   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_SEC   = 3'd1,
      RK_SMASK = 3'd2,
      RK_PRIM  = 3'd3,
      RK_PMASK = 3'd4
   } reg_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_tt_addr_dec.sv
module irq_tt_addr_dec
   import irq_tt_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int ADDR_W  = 4,
   parameter int GIDX_W  = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_kind_e         kind_o,
   output logic [GIDX_W-1:0] grp_o
);

   localparam int MASK_BASE = NUM_GRP;
   localparam int PRIM_ADDR = 2 * NUM_GRP;
   localparam int PMSK_ADDR = 2 * NUM_GRP + 1;

   logic [ADDR_W-1:0] off;

   always_comb begin
      kind_o = RK_NONE;
      off    = addr_i;
      if (int'(addr_i) < MASK_BASE) begin
         kind_o = RK_SEC;
      end else if (int'(addr_i) < PRIM_ADDR) begin
         kind_o = RK_SMASK;
         off    = addr_i - ADDR_W'(MASK_BASE);
      end else if (int'(addr_i) == PRIM_ADDR) begin
         kind_o = RK_PRIM;
      end else if (int'(addr_i) == PMSK_ADDR) begin
         kind_o = RK_PMASK;
      end
      grp_o = off[GIDX_W-1:0];
   end

endmodule

// File: rtl/irq_tt_sec_group.sv
module irq_tt_sec_group #(
   parameter int GRP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] evt_i,
   input  logic             clr_wr_i,
   input  logic             msk_wr_i,
   input  logic [GRP_W-1:0] wdata_i,
   output logic [GRP_W-1:0] stat_q,
   output logic [GRP_W-1:0] mask_q,
   output logic             summary_o
);

   logic [GRP_W-1:0] clr_vec;

   assign clr_vec = clr_wr_i ? wdata_i : '0;

   // Set has priority over clear so a colliding event is kept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_vec) | evt_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (msk_wr_i) begin
         mask_q <= wdata_i;
      end
   end

   assign summary_o = |(stat_q & ~mask_q);

endmodule

// File: rtl/irq_tt_prim_stage.sv
module irq_tt_prim_stage #(
   parameter int NUM_GRP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GRP-1:0] prim_i,
   input  logic               msk_wr_i,
   input  logic [NUM_GRP-1:0] wdata_i,
   output logic [NUM_GRP-1:0] pmask_q,
   output logic               irq_n_q
);

   logic any_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmask_q <= '1;
      end else if (msk_wr_i) begin
         pmask_q <= wdata_i;
      end
   end

   assign any_pending = |(prim_i & ~pmask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n_q <= 1'b1;
      end else begin
         irq_n_q <= ~any_pending;
      end
   end

endmodule

// File: rtl/irq_two_tier_ctrl.sv
module irq_two_tier_ctrl
   import irq_tt_pkg::*;
#(
   parameter  int NUM_GRP = 4,
   parameter  int GRP_W   = 8,
   localparam int ADDR_W  = idx_width(2 * NUM_GRP + 2),
   localparam int EVT_W   = NUM_GRP * GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [GRP_W-1:0]  wdata_i,
   output logic [GRP_W-1:0]  rdata_o,
   output logic              irq_n_o
);

   localparam int GIDX_W = idx_width(NUM_GRP);

   if (NUM_GRP < 1 || GRP_W < 1) begin : g_bad_size
      $error("irq_two_tier_ctrl: NUM_GRP and GRP_W must be at least 1");
   end
   if (NUM_GRP > GRP_W) begin : g_bad_prim
      $error("irq_two_tier_ctrl: primary word must fit in GRP_W bits");
   end

   reg_kind_e         kind;
   logic [GIDX_W-1:0] grp_sel;
   logic [EVT_W-1:0]  sec_flat;
   logic [EVT_W-1:0]  smask_flat;
   logic [NUM_GRP-1:0] prim_sum;
   logic [NUM_GRP-1:0] pmask_q;

   irq_tt_addr_dec #(
      .NUM_GRP (NUM_GRP),
      .ADDR_W  (ADDR_W),
      .GIDX_W  (GIDX_W)
   ) dec_i (
      .addr_i (addr_i),
      .kind_o (kind),
      .grp_o  (grp_sel)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic sel;
      assign sel = (grp_sel == GIDX_W'(g));

      irq_tt_sec_group #(
         .GRP_W (GRP_W)
      ) grp_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt_i     (evt_i[g*GRP_W +: GRP_W]),
         .clr_wr_i  (wr_en_i && kind == RK_SEC && sel),
         .msk_wr_i  (wr_en_i && kind == RK_SMASK && sel),
         .wdata_i   (wdata_i),
         .stat_q    (sec_flat[g*GRP_W +: GRP_W]),
         .mask_q    (smask_flat[g*GRP_W +: GRP_W]),
         .summary_o (prim_sum[g])
      );
   end

   irq_tt_prim_stage #(
      .NUM_GRP (NUM_GRP)
   ) prim_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prim_i   (prim_sum),
      .msk_wr_i (wr_en_i && kind == RK_PMASK),
      .wdata_i  (wdata_i[NUM_GRP-1:0]),
      .pmask_q  (pmask_q),
      .irq_n_q  (irq_n_o)
   );

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_sel == GIDX_W'(g)) begin
            if (kind == RK_SEC)   rdata_o = sec_flat[g*GRP_W +: GRP_W];
            if (kind == RK_SMASK) rdata_o = smask_flat[g*GRP_W +: GRP_W];
         end
      end
      if (kind == RK_PRIM)  rdata_o = GRP_W'(prim_sum);
      if (kind == RK_PMASK) rdata_o = GRP_W'(pmask_q);
   end

endmodule

// File: rtl/irq_tt_checker.sv
module irq_tt_checker #(
   parameter int NUM_GRP = 4,
   parameter int GRP_W   = 8,
   parameter int ADDR_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_GRP*GRP_W-1:0] evt_i,
   input logic                     wr_en_i,
   input logic [ADDR_W-1:0]        addr_i,
   input logic [GRP_W-1:0]         wdata_i,
   input logic                     irq_n_o,
   input logic [NUM_GRP*GRP_W-1:0] sec_q,
   input logic [NUM_GRP*GRP_W-1:0] smask_q,
   input logic [NUM_GRP-1:0]       prim,
   input logic [NUM_GRP-1:0]       pmask_q
);

   logic [NUM_GRP*GRP_W-1:0] clr;

   always_comb begin
      clr = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (wr_en_i && addr_i == ADDR_W'(g)) clr[g*GRP_W +: GRP_W] = wdata_i;
      end
   end

   // R1: leaving reset, nothing is pending and the request is idle
   a_r1_reset_idle: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_n_o && sec_q == '0 && pmask_q == '1));

   // R2 and R8: a pulsed bit is set at the next edge, whatever the write did
   a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((sec_q & $past(evt_i)) == $past(evt_i)));

   // R3: a set bit only drops when it was written with 1
   a_r3_only_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(sec_q) & ~$past(clr)) & ~sec_q) == '0));

   // R4: with no event and no write, the status stays put
   a_r4_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && evt_i == '0) |=> $stable(sec_q));

   // R6: with every set bit masked, no primary bit is raised
   a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      ((sec_q & ~smask_q) == '0) |-> (prim == '0));

   // R7: the request follows the unmasked primaries one edge later
   a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n_o == ~|($past(prim) & ~$past(pmask_q))));

endmodule

bind irq_two_tier_ctrl irq_tt_checker #(
   .NUM_GRP (NUM_GRP),
   .GRP_W   (GRP_W),
   .ADDR_W  (ADDR_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_i   (evt_i),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .irq_n_o (irq_n_o),
   .sec_q   (sec_flat),
   .smask_q (smask_flat),
   .prim    (prim_sum),
   .pmask_q (pmask_q)
);

// File: tb/irq_two_tier_ctrl_tb.sv
module irq_two_tier_ctrl_tb_top;

   localparam int NG = 4;
   localparam int GW = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*GW-1:0] evt = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [GW-1:0] wdata = '0;
   logic [GW-1:0] rdata;
   logic          irq_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      bit         chk_rd;
      logic [GW-1:0] exp_rd;
      bit         chk_irq;
      logic       exp_irq;
      string      tag;
   } item_t;

   item_t sb_q[$];

   always #2.5 clk = ~clk;

   irq_two_tier_ctrl #(.NUM_GRP(NG), .GRP_W(GW)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt),
      .wr_en_i (wr_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_n_o (irq_n)
   );

   // Monitor: pops expectations pushed this cycle, samples 1 ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.chk_rd) begin
               checks++;
               if (rdata !== it.exp_rd) begin
                  fails++;
                  $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp_rd);
               end
            end
            if (it.chk_irq) begin
               checks++;
               if (irq_n !== it.exp_irq) begin
                  fails++;
                  $display("FAIL %s: irq_n actual=%b expected=%b", it.tag, irq_n, it.exp_irq);
               end
            end
         end
      end
   end

   task automatic cyc(input logic [NG*GW-1:0] e, input logic we,
                      input logic [AW-1:0] a, input logic [GW-1:0] d);
      @(negedge clk);
      evt = e; wr_en = we; addr = a; wdata = d;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [GW-1:0] d);
      cyc('0, 1'b1, a, d);
   endtask

   task automatic pulse(input logic [NG*GW-1:0] e);
      cyc(e, 1'b0, '0, '0);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [GW-1:0] exp, input string tag);
      item_t it;
      cyc('0, 1'b0, a, '0);
      it.chk_rd = 1'b1; it.exp_rd = exp; it.chk_irq = 1'b0; it.exp_irq = 1'b1; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      item_t it;
      cyc('0, 1'b0, '0, '0);
      cyc('0, 1'b0, '0, '0);
      it.chk_rd = 1'b0; it.exp_rd = '0; it.chk_irq = 1'b1; it.exp_irq = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic check_reset_state(input string tag);
      for (int g = 0; g < NG; g++) rd(AW'(g), 8'h00, tag);
      for (int g = 0; g < NG; g++) rd(AW'(NG + g), 8'hFF, tag);
      rd(4'd8, 8'h00, tag);
      rd(4'd9, 8'h0F, tag);
      chk_irq(1'b1, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset_state("R1 reset state");

      // R2/R9: group 1 bit 3 is evt bit 11
      pulse(32'h0000_0800);
      rd(4'd1, 8'h08, "R2 R9 sticky latch group1 bit3");
      rd(4'd1, 8'h08, "R4 second read unchanged");
      rd(4'd8, 8'h00, "R6 masked bit absent from primary");
      chk_irq(1'b1, "R6 masked bit raises no irq");
      rd(4'd1, 8'h08, "R6 masked bit still readable");

      // R5/R10: unmask at the secondary level only
      wr(4'd5, 8'hF7);
      rd(4'd8, 8'h02, "R5 primary bit1 set");
      chk_irq(1'b1, "R10 primary mask blocks irq");
      wr(4'd9, 8'h0D);
      rd(4'd9, 8'h0D, "R9 primary mask readback");
      chk_irq(1'b0, "R7 irq asserted");

      // R3: zeros and foreign ones leave the bit
      wr(4'd1, 8'h00);
      rd(4'd1, 8'h08, "R3 write zero no effect");
      wr(4'd1, 8'h04);
      rd(4'd1, 8'h08, "R3 clear other bit no effect");
      wr(4'd1, 8'h08);
      rd(4'd1, 8'h00, "R3 write one clears");
      rd(4'd8, 8'h00, "R5 primary drops after clear");
      chk_irq(1'b1, "R7 irq released");

      // R8: set beats clear in the same cycle
      cyc(32'h0000_0800, 1'b1, 4'd1, 8'h08);
      rd(4'd1, 8'h08, "R8 set wins over clear");
      cyc(32'h0000_0400, 1'b1, 4'd1, 8'hFF);
      rd(4'd1, 8'h04, "R8 collide bit kept, others cleared");
      wr(4'd1, 8'hFF);
      rd(4'd1, 8'h00, "R3 full clear");

      // Several groups at once: group0 bit0, group3 bit7
      pulse(32'h8000_0001);
      rd(4'd0, 8'h01, "R2 group0 bit0");
      rd(4'd3, 8'h80, "R2 R9 group3 bit7");
      rd(4'd8, 8'h00, "R6 both masked");
      wr(4'd7, 8'h00);
      rd(4'd8, 8'h08, "R5 primary bit3");
      chk_irq(1'b1, "R10 pmask bit3 blocks");
      wr(4'd9, 8'h00);
      chk_irq(1'b0, "R7 irq from group3");
      wr(4'd9, 8'h0F);
      chk_irq(1'b1, "R10 all primaries masked");

      // R9: unmapped and read-only addresses ignore writes
      wr(4'd10, 8'hFF);
      rd(4'd10, 8'h00, "R9 unmapped reads zero");
      wr(4'd8, 8'h00);
      rd(4'd8, 8'h08, "R9 primary status read-only");
      rd(4'd0, 8'h01, "R9 unmapped write left group0");

      // R1: reset in mid-run restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check_reset_state("R1 reset after activity");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule